// File: doc/BRIEF.md
# Mode-Banked Shadow Register File

This block is a 64-bit integer register file holding 31 general registers and a constant-zero register at index 31. A second bank of eight shadow registers stands in for a fixed set of general registers whenever the privileged-mode input is high. The shadow set is indices 8 through 14 and index 25. Two combinational read ports and one clocked write port take a 5-bit register index, and they always see the bank that the current mode selects.

Two further ports reach the storage. The privileged port takes a 3-bit selector and always reaches the normal copies of the eight shadowed registers, even in privileged mode. This lets privileged code save or restore the values it has hidden. The debug port has one read path and one write path, and it uses the same mode-dependent mapping as the instruction ports. The mode flag comes from outside the block. A mode change takes effect at once and copies nothing between the banks.

Top module: `mode_bank_regfile`

## Requirements
- R1: Index 31 reads as zero on every port and in both modes, and a write to index 31 changes no register.
- R2: With `privMode` at 0, indices 0 to 30 on both read ports, the write port and the debug port address the normal bank, and the shadow bank cannot be observed.
- R3: With `privMode` at 1, indices 8 to 14 address shadow entries 0 to 6, in that order.
- R4: With `privMode` at 1, index 25 addresses shadow entry 7, and all other indices 0 to 30 still address the normal bank.
- R5: The privileged port selector values 0 to 6 reach normal registers 8 to 14 and value 7 reaches normal register 25, for reads and writes in either mode.
- R6: The debug port reads and writes through the same mode-dependent mapping as the instruction ports.
- R7: A write lands at the rising clock edge. A read in the same cycle returns the previous value, and the new value is visible from the next cycle.
- R8: Reset (active-low `rstN`) clears every normal and shadow register to zero.
- R9: A change of `privMode` changes the mapping for accesses in the very next cycle, and no data moves between the banks.
- R10: When several write ports hit the same physical register in one cycle, the debug write wins over the privileged write, and the privileged write wins over the instruction write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| privMode | input | 1 | 1 selects the shadow mapping |
| rdAddrA | input | 5 | Read port A index |
| rdDataA | output | 64 | Read port A data |
| rdAddrB | input | 5 | Read port B index |
| rdDataB | output | 64 | Read port B data |
| wrEn | input | 1 | Instruction write enable |
| wrAddr | input | 5 | Instruction write index |
| wrData | input | 64 | Instruction write data |
| prRdSel | input | 3 | Privileged read selector |
| prRdData | output | 64 | Privileged read data |
| prWrEn | input | 1 | Privileged write enable |
| prWrSel | input | 3 | Privileged write selector |
| prWrData | input | 64 | Privileged write data |
| dbgAddr | input | 5 | Debug read/write index |
| dbgRdData | output | 64 | Debug read data |
| dbgWrEn | input | 1 | Debug write enable |
| dbgWrData | input | 64 | Debug write data |

## Verification
The bench writes the same index in both modes and then switches the mode back and forth. A design that copied or swapped data between the banks on a mode change would return the value written in the other mode. It uses the privileged port in privileged mode to reach the normal copies behind the shadows. A wrong selector decode, or one that followed the mode, would return the shadow value or touch a register outside the shadowed set. It also drives colliding writes, which show a wrong priority order, and it writes and reads index 31 in both modes.

// File: rtl/mbr_pkg.sv
package mbr_pkg;
  localparam int ADDR_W = 5;
  localparam int PHYS_W = 6;
  localparam int SEL_W  = 3;
  localparam logic [PHYS_W-1:0] ZERO_PHYS = 6'd31;

  // phys index: bit5 set = shadow entry in bits 2:0, else normal index (31 = zero)
  typedef logic [PHYS_W-1:0] physT;

  typedef struct packed {
    logic wrA;
    physT wrPhysA;
    logic wrP;
    physT wrPhysP;
    logic wrD;
    physT wrPhysD;
    physT rdPhysA;
    physT rdPhysB;
    physT rdPhysP;
    physT rdPhysD;
  } strobeT;

  function automatic physT mapArch(input logic [ADDR_W-1:0] idx, input logic mode);
    if (mode && idx >= 5'd8 && idx <= 5'd14) return {1'b1, idx - 5'd8};
    if (mode && idx == 5'd25) return {1'b1, 5'd7};
    return {1'b0, idx};
  endfunction

  function automatic physT mapPriv(input logic [SEL_W-1:0] sel);
    if (sel == 3'd7) return {1'b0, 5'd25};
    return {1'b0, 5'd8 + {2'b00, sel}};
  endfunction
endpackage

// File: rtl/mbr_ctrl.sv
module mbr_ctrl
  import mbr_pkg::*;
(
  input  logic              privMode,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [SEL_W-1:0]  prRdSel,
  input  logic              prWrEn,
  input  logic [SEL_W-1:0]  prWrSel,
  input  logic [ADDR_W-1:0] dbgAddr,
  input  logic              dbgWrEn,
  output strobeT            strobes
);
  physT wrMapA;
  physT wrMapD;

  always_comb begin
    wrMapA          = mapArch(wrAddr, privMode);
    wrMapD          = mapArch(dbgAddr, privMode);
    strobes.wrA     = wrEn && (wrMapA != ZERO_PHYS);
    strobes.wrPhysA = wrMapA;
    strobes.wrP     = prWrEn;
    strobes.wrPhysP = mapPriv(prWrSel);
    strobes.wrD     = dbgWrEn && (wrMapD != ZERO_PHYS);
    strobes.wrPhysD = wrMapD;
    strobes.rdPhysA = mapArch(rdAddrA, privMode);
    strobes.rdPhysB = mapArch(rdAddrB, privMode);
    strobes.rdPhysP = mapPriv(prRdSel);
    strobes.rdPhysD = wrMapD;
  end
endmodule

// File: rtl/mbr_datapath.sv
module mbr_datapath
  import mbr_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NUM_ARCH = 31,
  parameter int SHADOW_N = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] prWrData,
  input  logic [DATA_W-1:0] dbgWrData,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  output logic [DATA_W-1:0] prRdData,
  output logic [DATA_W-1:0] dbgRdData
);
  localparam int SH_IDX_W = $clog2(SHADOW_N);

  logic [DATA_W-1:0] normBank   [NUM_ARCH];
  logic [DATA_W-1:0] shadowBank [SHADOW_N];

  function automatic logic [DATA_W-1:0] pickWrite(input physT self, input logic [DATA_W-1:0] keep);
    if (strobes.wrD && strobes.wrPhysD == self) return dbgWrData;
    if (strobes.wrP && strobes.wrPhysP == self) return prWrData;
    if (strobes.wrA && strobes.wrPhysA == self) return wrData;
    return keep;
  endfunction

  for (genvar i = 0; i < NUM_ARCH; i++) begin : g_norm
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) normBank[i] <= '0;
      else       normBank[i] <= pickWrite({1'b0, 5'(i)}, normBank[i]);
    end
  end

  for (genvar j = 0; j < SHADOW_N; j++) begin : g_shadow
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) shadowBank[j] <= '0;
      else       shadowBank[j] <= pickWrite({1'b1, 5'(j)}, shadowBank[j]);
    end
  end

  function automatic logic [DATA_W-1:0] readPhys(input physT p);
    if (p[5]) return shadowBank[p[SH_IDX_W-1:0]];
    if (p == ZERO_PHYS) return '0;
    return normBank[p[4:0]];
  endfunction

  always_comb begin
    rdDataA   = readPhys(strobes.rdPhysA);
    rdDataB   = readPhys(strobes.rdPhysB);
    prRdData  = readPhys(strobes.rdPhysP);
    dbgRdData = readPhys(strobes.rdPhysD);
  end
endmodule

// File: rtl/mode_bank_regfile.sv
module mode_bank_regfile
  import mbr_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              privMode,
  input  logic [4:0]        rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [4:0]        rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [4:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [2:0]        prRdSel,
  output logic [DATA_W-1:0] prRdData,
  input  logic              prWrEn,
  input  logic [2:0]        prWrSel,
  input  logic [DATA_W-1:0] prWrData,
  input  logic [4:0]        dbgAddr,
  output logic [DATA_W-1:0] dbgRdData,
  input  logic              dbgWrEn,
  input  logic [DATA_W-1:0] dbgWrData
);
  strobeT strobes;

  mbr_ctrl u_ctrl (
    .privMode(privMode), .rdAddrA(rdAddrA), .rdAddrB(rdAddrB),
    .wrEn(wrEn), .wrAddr(wrAddr), .prRdSel(prRdSel),
    .prWrEn(prWrEn), .prWrSel(prWrSel), .dbgAddr(dbgAddr),
    .dbgWrEn(dbgWrEn), .strobes(strobes)
  );

  mbr_datapath #(.DATA_W(DATA_W), .NUM_ARCH(31), .SHADOW_N(8)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .wrData(wrData), .prWrData(prWrData), .dbgWrData(dbgWrData),
    .rdDataA(rdDataA), .rdDataB(rdDataB),
    .prRdData(prRdData), .dbgRdData(dbgRdData)
  );
endmodule

// File: rtl/mbr_checks.sv
module mbr_checks #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              privMode,
  input logic [4:0]        rdAddrA,
  input logic [DATA_W-1:0] rdDataA,
  input logic [4:0]        rdAddrB,
  input logic [DATA_W-1:0] rdDataB,
  input logic              wrEn,
  input logic [4:0]        wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              prWrEn,
  input logic [2:0]        prRdSel,
  input logic [DATA_W-1:0] prRdData,
  input logic [4:0]        dbgAddr,
  input logic [DATA_W-1:0] dbgRdData,
  input logic              dbgWrEn
);
  logic seenCycle;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenCycle <= 1'b0;
    else       seenCycle <= 1'b1;
  end

  p_zero_read_r1: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddrA == 5'd31) |-> (rdDataA == '0));

  p_ports_agree_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddrA == rdAddrB) |-> (rdDataA == rdDataB));

  p_debug_same_map_r6: assert property (@(posedge clk) disable iff (!rstN)
    (dbgAddr == rdAddrA) |-> (dbgRdData == rdDataA));

  p_priv_normal_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!privMode && dbgAddr == ((prRdSel == 3'd7) ? 5'd25 : 5'd8 + {2'b00, prRdSel}))
      |-> (dbgRdData == prRdData));

  p_write_next_r7: assert property (@(posedge clk) disable iff (!rstN)
    (seenCycle && $past(wrEn && !prWrEn && !dbgWrEn && wrAddr != 5'd31)
      && rdAddrA == $past(wrAddr) && privMode == $past(privMode))
      |-> (rdDataA == $past(wrData)));

  p_reset_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    !seenCycle |-> (rdDataA == '0 && rdDataB == '0 && prRdData == '0));
endmodule

bind mode_bank_regfile mbr_checks #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .privMode(privMode),
  .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
  .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .prWrEn(prWrEn),
  .prRdSel(prRdSel), .prRdData(prRdData), .dbgAddr(dbgAddr),
  .dbgRdData(dbgRdData), .dbgWrEn(dbgWrEn)
);

// File: tb/mode_bank_regfile_tb.sv
module mode_bank_regfile_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        privMode = 1'b0;
  logic [4:0]  rdAddrA = '0, rdAddrB = '0, wrAddr = '0, dbgAddr = '0;
  logic [63:0] rdDataA, rdDataB, prRdData, dbgRdData;
  logic        wrEn = 1'b0, prWrEn = 1'b0, dbgWrEn = 1'b0;
  logic [63:0] wrData = '0, prWrData = '0, dbgWrData = '0;
  logic [2:0]  prRdSel = '0, prWrSel = '0;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mode_bank_regfile u_dut (
    .clk(clk), .rstN(rstN), .privMode(privMode),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .prRdSel(prRdSel), .prRdData(prRdData), .prWrEn(prWrEn), .prWrSel(prWrSel),
    .prWrData(prWrData), .dbgAddr(dbgAddr), .dbgRdData(dbgRdData),
    .dbgWrEn(dbgWrEn), .dbgWrData(dbgWrData)
  );

  typedef struct packed {
    logic        mode;
    logic        wr;
    logic [4:0]  wa;
    logic [63:0] wd;
    logic [4:0]  ra;
    logic [63:0] exp;
  } vecT;

  // expected read value is the state before this row's write lands
  localparam vecT VECS [15] = '{
    '{1'b0, 1'b1, 5'd8,  64'h11, 5'd8,  64'h0 },
    '{1'b0, 1'b1, 5'd25, 64'h22, 5'd8,  64'h11},
    '{1'b1, 1'b1, 5'd8,  64'h33, 5'd25, 64'h0 },
    '{1'b1, 1'b1, 5'd25, 64'h44, 5'd8,  64'h33},
    '{1'b0, 1'b0, 5'd0,  64'h0,  5'd8,  64'h11},
    '{1'b0, 1'b0, 5'd0,  64'h0,  5'd25, 64'h22},
    '{1'b1, 1'b0, 5'd0,  64'h0,  5'd25, 64'h44},
    '{1'b1, 1'b1, 5'd14, 64'h55, 5'd7,  64'h0 },
    '{1'b1, 1'b1, 5'd31, 64'h66, 5'd14, 64'h55},
    '{1'b0, 1'b0, 5'd0,  64'h0,  5'd31, 64'h0 },
    '{1'b0, 1'b0, 5'd0,  64'h0,  5'd14, 64'h0 },
    '{1'b1, 1'b1, 5'd26, 64'h77, 5'd14, 64'h55},
    '{1'b0, 1'b0, 5'd0,  64'h0,  5'd26, 64'h77},
    '{1'b1, 1'b1, 5'd0,  64'h88, 5'd26, 64'h77},
    '{1'b0, 1'b0, 5'd0,  64'h0,  5'd0,  64'h88}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    wrEn = 1'b0; prWrEn = 1'b0; dbgWrEn = 1'b0;
  endtask

  task automatic rdCheck(input string req, input logic mode, input logic [4:0] a, input logic [63:0] exp);
    @(negedge clk);
    idle();
    privMode = mode; rdAddrA = a; rdAddrB = a; dbgAddr = a;
    #2;
    check(req, rdDataA, exp);
    check(req, rdDataB, exp);
    check(req, dbgRdData, exp);
  endtask

  initial begin
    #4000000;
    checks++; errors++;
    $display("FAIL watchdog all actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R8: every index reads zero after reset in both modes
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < 32; a++) begin
        @(negedge clk);
        privMode = m[0]; rdAddrA = 5'(a); rdAddrB = 5'(31 - a);
        #2;
        check("R8 reset", rdDataA, 64'h0);
        check("R8 reset", rdDataB, 64'h0);
      end
    end

    // table: R1 R2 R3 R4 R7 R9
    for (int k = 0; k < 15; k++) begin
      @(negedge clk);
      privMode = VECS[k].mode; wrEn = VECS[k].wr; wrAddr = VECS[k].wa;
      wrData = VECS[k].wd; rdAddrA = VECS[k].ra; rdAddrB = VECS[k].ra;
      #2;
      check($sformatf("R7/R2/R3/R4/R9 row %0d", k), rdDataA, VECS[k].exp);
      check($sformatf("R7 portB row %0d", k), rdDataB, VECS[k].exp);
    end

    // R5: privileged port reaches normal copies while shadows are active
    @(negedge clk);
    idle(); privMode = 1'b1; prRdSel = 3'd0;
    #2 check("R5 sel0", prRdData, 64'h11);
    prRdSel = 3'd7;
    #1 check("R5 sel7", prRdData, 64'h22);
    prWrEn = 1'b1; prWrSel = 3'd6; prWrData = 64'h99;
    rdCheck("R5 shadow6 untouched", 1'b1, 5'd14, 64'h55);
    rdCheck("R5 normal14 written", 1'b0, 5'd14, 64'h99);

    // R6: debug writes follow the mode map
    @(negedge clk);
    idle(); privMode = 1'b1; dbgAddr = 5'd9; dbgWrEn = 1'b1; dbgWrData = 64'hAA;
    rdCheck("R6 dbg shadow1", 1'b1, 5'd9, 64'hAA);
    rdCheck("R6 dbg normal9 clean", 1'b0, 5'd9, 64'h0);
    rdCheck("R6 dbg read shadow0", 1'b1, 5'd8, 64'h33);

    // R1: debug write to 31 in privileged mode has no effect
    @(negedge clk);
    idle(); privMode = 1'b1; dbgAddr = 5'd31; dbgWrEn = 1'b1; dbgWrData = 64'hDEAD;
    rdCheck("R1 dbg zero", 1'b1, 5'd31, 64'h0);

    // R10: write priority
    @(negedge clk);
    idle(); privMode = 1'b0;
    wrEn = 1'b1; wrAddr = 5'd10; wrData = 64'h1;
    prWrEn = 1'b1; prWrSel = 3'd2; prWrData = 64'h2;
    dbgWrEn = 1'b1; dbgAddr = 5'd10; dbgWrData = 64'h3;
    rdCheck("R10 dbg wins", 1'b0, 5'd10, 64'h3);
    @(negedge clk);
    idle(); privMode = 1'b0;
    wrEn = 1'b1; wrAddr = 5'd10; wrData = 64'h4;
    prWrEn = 1'b1; prWrSel = 3'd2; prWrData = 64'h5;
    rdCheck("R10 priv wins", 1'b0, 5'd10, 64'h5);
    @(negedge clk);
    idle(); privMode = 1'b1;
    wrEn = 1'b1; wrAddr = 5'd10; wrData = 64'hB1;
    prWrEn = 1'b1; prWrSel = 3'd2; prWrData = 64'hB2;
    rdCheck("R10 split shadow2", 1'b1, 5'd10, 64'hB1);
    rdCheck("R10 split normal10", 1'b0, 5'd10, 64'hB2);

    // R8: reset mid-run clears both banks
    @(negedge clk);
    idle(); rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    rdCheck("R8 shadow cleared", 1'b1, 5'd8, 64'h0);
    rdCheck("R8 normal cleared", 1'b0, 5'd25, 64'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule